// File: doc/BRIEF.md
# Bus Access Timeout Monitor

This block sits between one bus master and the register space it targets, on a simple valid/ready request path. It counts the cycles of each outstanding access. When an access stays unanswered for longer than a programmable number of cycles, the monitor ends the access itself: it gives the master a ready with an error flag, so the master is released. It also raises a sticky interrupt and records the address of the stalled access together with a 7-bit tag built from the master ID and its permission level.

Software uses a three-word register interface. A control word holds the threshold, the protection enable and a write-to-clear bit for the interrupt. Two read-only words return the captured address and the captured tag. The record always keeps the first hung access seen after the last acknowledge. While protection is off, requests and responses pass through untouched.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset the threshold is 65535, protection is enabled, the interrupt is low and both capture words read 0. With this default, an unanswered access is aborted in its 65536th cycle.
- R2: While no timeout is being taken, `s_valid` follows `m_valid`, and `m_ready`/`m_err` follow `s_ready`/`s_err` of the slave in the same cycle.
- R3: The first cycle of a pending access has count 0. With threshold T, an access that is still unanswered is aborted in its (T+1)th cycle. In that cycle `m_ready` and `m_err` are 1, `s_valid` is 0, and any slave response is discarded.
- R4: A threshold of 0 acts as 1, so an unanswered access is aborted in its second cycle.
- R5: A timeout sets `irq`, and `irq` stays set until software writes 1 to control bit 16.
- R6: On a timeout with no interrupt pending, the access address and the tag {perm[1:0], mid[4:0]} are captured. While the interrupt stays pending, later timeouts still abort but leave the capture unchanged.
- R7: Clearing the interrupt resets the captured tag to 0 and keeps the captured address.
- R8: Register select 0 is control: bits [15:0] threshold, bit 16 clear (write trigger, reads 0), bit 17 enable. Select 1 reads the address and select 2 reads the tag in bits [6:0]. Select 3 reads 0. Writes to selects 1 to 3 have no effect.
- R9: With protection off, no access is aborted and no interrupt is raised. Enabling protection during a pending access starts its count from 0.
- R10: A threshold write takes effect on the next cycle's comparison. If the pending count already reaches the new value, the access aborts in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_valid | input | 1 | Master request valid |
| m_addr | input | 32 | Master request address |
| m_mid | input | 5 | Requesting master ID |
| m_perm | input | 2 | Master permission level |
| m_ready | output | 1 | Access complete to master |
| m_err | output | 1 | Error response to master |
| s_valid | output | 1 | Request valid to slave |
| s_ready | input | 1 | Slave completes access |
| s_err | input | 1 | Slave error response |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Sticky timeout interrupt |

## Verification
A counter that is off by one moves the abort one cycle early or late, and the master handshake shows this in the cycle it happens. A capture that is overwritten or cleared by mistake shows on the next register read. A sticky flag that drops, or that never sets, shows on `irq` one cycle after the event. The reference model checks every output in every cycle, so any wrong internal state is reported at the first cycle it reaches a port.

// File: rtl/tmo_pkg.sv
// Package: shared constants and the register-select encoding of the
// bus timeout monitor. Assumes a 32-bit register data path.
package tmo_pkg;
    localparam int REG_W   = 32;
    localparam int MID_W   = 5;
    localparam int PERM_W  = 2;
    localparam int TAG_W   = MID_W + PERM_W;
    localparam int CLR_BIT = 16;
    localparam int EN_BIT  = 17;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_TAG  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmo_cfg.sv
// Control word storage: threshold and protection enable, plus a one-cycle
// clear pulse decoded from a control write. Assumes THR_W <= CLR_BIT.
module tmo_cfg
    import tmo_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [REG_W-1:0] wdata,
    output logic [THR_W-1:0] thr,
    output logic             en,
    output logic             clr_pulse
);
    logic ctrl_wr;
    assign ctrl_wr   = wr && (sel == SEL_CTRL);
    assign clr_pulse = ctrl_wr && wdata[CLR_BIT];

    // Hold threshold and enable; both reset to their protective defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= '1;
            en  <= 1'b1;
        end else if (ctrl_wr) begin
            thr <= wdata[THR_W-1:0];
            en  <= wdata[EN_BIT];
        end
    end
endmodule

// File: rtl/tmo_counter.sv
// Pending-cycle counter. It counts the cycles of the current access and flags
// a timeout while the count is at or above the effective threshold (0 acts
// as 1). Assumes the request stays valid until it completes or is aborted.
module tmo_counter #(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [THR_W-1:0] thr,
    input  logic             req_valid,
    input  logic             req_done,
    output logic             hit
);
    logic [THR_W-1:0] cnt;
    logic [THR_W-1:0] thr_eff;

    // Map a zero threshold onto one cycle.
    always_comb thr_eff = (thr == '0) ? THR_W'(1) : thr;

    assign hit = en && req_valid && (cnt >= thr_eff);

    // Count while pending; restart on completion, abort, idle or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || !req_valid || req_done || hit) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmo_capture.sv
// Sticky interrupt and first-event capture. A timeout captures only when no
// interrupt is pending, or when the pending one is cleared in the same cycle.
// Clearing resets the tag but keeps the address.
module tmo_capture #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [TAG_W-1:0]  tag_in,
    output logic              irq,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [TAG_W-1:0]  cap_tag
);
    logic take;
    assign take = hit && (!irq || clr);

    // Interrupt flag: set by a timeout, dropped by an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq <= 1'b0;
        else if (hit) irq <= 1'b1;
        else if (clr) irq <= 1'b0;
    end

    // Capture words: record the first event, clear the tag on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_tag  <= '0;
        end else if (take) begin
            cap_addr <= addr_in;
            cap_tag  <= tag_in;
        end else if (clr) begin
            cap_tag  <= '0;
        end
    end
endmodule

// File: rtl/bus_timeout_monitor.sv
// Top: sits on a valid/ready request path, aborts accesses that stay
// unanswered past the threshold, and exposes three register words.
// Assumes a single outstanding access and a combinational slave response.
module bus_timeout_monitor
    import tmo_pkg::*;
#(
    parameter int THR_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 m_valid,
    input  logic [ADDR_W-1:0]    m_addr,
    input  logic [MID_W-1:0]     m_mid,
    input  logic [PERM_W-1:0]    m_perm,
    output logic                 m_ready,
    output logic                 m_err,
    output logic                 s_valid,
    input  logic                 s_ready,
    input  logic                 s_err,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq
);
    logic [THR_W-1:0]  thr;
    logic              prot_en;
    logic              clr_pulse;
    logic              timeout_hit;
    logic              slave_done;
    logic [ADDR_W-1:0] cap_addr;
    logic [TAG_W-1:0]  cap_tag;

    tmo_cfg #(.THR_W(THR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .thr(thr), .en(prot_en), .clr_pulse(clr_pulse)
    );

    tmo_counter #(.THR_W(THR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(prot_en), .thr(thr),
        .req_valid(m_valid), .req_done(slave_done), .hit(timeout_hit)
    );

    tmo_capture #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .hit(timeout_hit), .clr(clr_pulse),
        .addr_in(m_addr), .tag_in({m_perm, m_mid}),
        .irq(irq), .cap_addr(cap_addr), .cap_tag(cap_tag)
    );

    // Request path: an abort hides the request from the slave and answers it.
    assign s_valid    = m_valid && !timeout_hit;
    assign slave_done = s_valid && s_ready;
    assign m_ready    = timeout_hit || slave_done;
    assign m_err      = timeout_hit || (slave_done && s_err);

    // Register readback; the clear bit always reads as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[THR_W-1:0] = thr;
                reg_rdata[EN_BIT]    = prot_en;
            end
            SEL_ADDR: reg_rdata[ADDR_W-1:0] = cap_addr;
            SEL_TAG:  reg_rdata[TAG_W-1:0]  = cap_tag;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmo_monitor_chk.sv
// Checker: temporal properties of the timeout monitor, bound to its top.
module tmo_monitor_chk #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_valid,
    input logic              m_ready,
    input logic              m_err,
    input logic              s_valid,
    input logic              s_ready,
    input logic              prot_en,
    input logic              clr_pulse,
    input logic              timeout_hit,
    input logic              irq,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [TAG_W-1:0]  cap_tag
);
    AST_ABORT_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |-> (m_ready && m_err)); // R3
    AST_ABORT_HIDES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |-> !s_valid); // R3
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_pulse) |=> irq); // R5
    AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |=> irq); // R5
    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_pulse) |=> ($stable(cap_addr) && $stable(cap_tag))); // R6
    AST_TAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !timeout_hit) |=> (cap_tag == '0)); // R7
    AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |-> (m_ready == (m_valid && s_ready))); // R9
endmodule

bind bus_timeout_monitor tmo_monitor_chk #(.ADDR_W(ADDR_W), .TAG_W(tmo_pkg::TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_err(m_err), .s_valid(s_valid), .s_ready(s_ready), .prot_en(prot_en),
    .clr_pulse(clr_pulse), .timeout_hit(timeout_hit), .irq(irq),
    .cap_addr(cap_addr), .cap_tag(cap_tag)
);

// File: tb/tb_bus_timeout_monitor.sv
module tb_bus_timeout_monitor;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        m_valid = 0;
    logic [31:0] m_addr = 0;
    logic [4:0]  m_mid = 0;
    logic [1:0]  m_perm = 0;
    logic        m_ready, m_err, s_valid, irq;
    logic        s_ready = 0, s_err = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bus_timeout_monitor dut (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_addr(m_addr),
        .m_mid(m_mid), .m_perm(m_perm), .m_ready(m_ready), .m_err(m_err),
        .s_valid(s_valid), .s_ready(s_ready), .s_err(s_err), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural reference state.
    int      r_thr, r_cnt;
    bit      r_en, r_irq, r_live;
    longint  r_addr;
    int      r_tag;

    function automatic bit r_fire();
        int eff = (r_thr == 0) ? 1 : r_thr;
        return r_en && m_valid && (r_cnt >= eff);
    endfunction

    task automatic check(string tag, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each edge, from the inputs held since the last edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            r_thr = 65535; r_en = 1; r_irq = 0; r_addr = 0; r_tag = 0; r_cnt = 0; r_live = 1;
        end else begin
            bit f, clr, done;
            f    = r_fire();
            done = f || (m_valid && s_ready);
            clr  = reg_wr && reg_sel == 0 && reg_wdata[16];
            if (f && (!r_irq || clr)) begin r_addr = m_addr; r_tag = {m_perm, m_mid}; end
            else if (clr) r_tag = 0;
            if (f) r_irq = 1; else if (clr) r_irq = 0;
            if (!r_en || !m_valid || done) r_cnt = 0;
            else if (r_cnt < 65535) r_cnt = r_cnt + 1;
            if (reg_wr && reg_sel == 0) begin r_thr = reg_wdata[15:0]; r_en = reg_wdata[17]; end
        end
    end

    // Compare every output mid-cycle against the model.
    always @(negedge clk) begin
        if (rst_n && r_live && !finished) begin
            bit f;
            longint exp_rd;
            f = r_fire();
            check("R2 s_valid", s_valid, m_valid && !f);
            check("R3 m_ready", m_ready, f || (m_valid && s_ready));
            check("R3 m_err", m_err, f || (m_valid && s_ready && s_err));
            check("R5 irq", irq, r_irq);
            case (reg_sel)
                2'd0: exp_rd = (longint'(r_en) << 17) | r_thr;
                2'd1: exp_rd = r_addr;
                2'd2: exp_rd = r_tag;
                default: exp_rd = 0;
            endcase
            check("R8 rdata", reg_rdata, exp_rd);
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic wr_reg(logic [1:0] sel, logic [31:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d; tick(); reg_wr = 0; reg_sel = 0;
    endtask

    task automatic rd_chk(logic [1:0] sel, longint exp, string tag);
        reg_sel = sel; @(negedge clk); check(tag, reg_rdata, exp); tick(); reg_sel = 0;
    endtask

    task automatic start(logic [31:0] a, logic [4:0] id, logic [1:0] p);
        m_valid = 1; m_addr = a; m_mid = id; m_perm = p;
    endtask

    // Count cycles of the pending access until the master sees ready.
    task automatic wait_done(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!m_ready && n < 70000);
        tick(); m_valid = 0;
    endtask

    int n;
    logic [31:0] keep;

    initial begin
        repeat (3) tick();
        rst_n = 1;
        // R1 reset values
        @(negedge clk); check("R1 irq", irq, 0);
        tick();
        rd_chk(0, 32'h0002_FFFF, "R1 ctrl");
        rd_chk(1, 0, "R1 addr");
        rd_chk(2, 0, "R1 tag");

        // R2 slave answers with error after three cycles
        start(32'h1000_0004, 5'd3, 2'd1); tick(); tick(); tick();
        s_ready = 1; s_err = 1;
        @(negedge clk); check("R2 m_ready", m_ready, 1); check("R2 m_err", m_err, 1);
        tick(); m_valid = 0; s_ready = 0; s_err = 0;
        tick();

        // R1 default threshold: abort in the 65536th cycle
        start(32'hA5A5_0010, 5'd17, 2'd2);
        wait_done(n); check("R1 default abort cycle", n, 65536);
        @(negedge clk); check("R5 irq set", irq, 1);
        tick();
        rd_chk(1, 32'hA5A5_0010, "R6 addr captured");
        rd_chk(2, {2'd2, 5'd17}, "R6 tag captured");

        // R7 clear: tag zeroed, address kept; R8 clear bit reads 0
        wr_reg(0, 32'h0003_0003);
        @(negedge clk); check("R5 irq cleared", irq, 0); tick();
        rd_chk(2, 0, "R7 tag cleared");
        rd_chk(1, 32'hA5A5_0010, "R7 addr kept");
        rd_chk(0, 32'h0002_0003, "R8 ctrl readback");

        // R3 threshold 3 aborts in the fourth cycle
        start(32'hB000_0020, 5'd9, 2'd0);
        wait_done(n); check("R3 abort cycle", n, 4);
        tick();
        // R6 second timeout while pending does not overwrite
        start(32'hC000_0030, 5'd1, 2'd3);
        wait_done(n); check("R6 second abort", n, 4);
        rd_chk(1, 32'hB000_0020, "R6 capture frozen");

        // R4 threshold 0 acts as 1
        wr_reg(0, 32'h0003_0000);
        start(32'hD000_0040, 5'd4, 2'd1);
        wait_done(n); check("R4 zero threshold", n, 2);

        // R9 disabled: no abort, then enable mid-access restarts count
        wr_reg(0, 32'h0001_0003);
        start(32'hE000_0050, 5'd6, 2'd0);
        repeat (20) tick();
        @(negedge clk); check("R9 no abort", m_ready, 0); check("R9 no irq", irq, 0);
        tick();
        wr_reg(0, 32'h0002_0003);
        wait_done(n); check("R9 count restarts", n, 4);

        // R10 threshold lowered while pending
        wr_reg(0, 32'h0002_0064);
        start(32'hF000_0060, 5'd2, 2'd2);
        repeat (10) tick();
        wr_reg(0, 32'h0002_0005);
        @(negedge clk); check("R10 abort after lower", m_err, 1);
        tick(); m_valid = 0; tick();

        // R8 writes to read-only words are ignored; select 3 reads 0
        reg_sel = 1; @(negedge clk); keep = reg_rdata; tick();
        wr_reg(1, 32'hDEAD_BEEF);
        wr_reg(2, 32'h0000_007F);
        rd_chk(1, keep, "R8 addr write ignored");
        rd_chk(3, 0, "R8 select 3");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1900000;
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule